// File: doc/BRIEF.md
# SIMD Shift-Left-and-Insert Unit

This block executes a shift-left-and-insert operation on a 128-bit vector register. It takes a 32-bit instruction word, the source register value and the current contents of the destination register. It decodes the instruction in either its scalar form or its vector form. Each element of the source is shifted left by an immediate amount and merged into the matching destination element. The low bit positions left empty by the shift keep the destination's old bits, and bits pushed past the top of an element are dropped.

The element width and the shift amount share one 7-bit immediate `{immh, immb}`. The leading one of `immh` picks the lane width. The lane width is then subtracted from the immediate to give the shift. Results, flags and register indices are registered, so they appear one clock after the inputs are presented. Reset clears all outputs to zero. There is no multi-state control: every cycle is an independent decode-and-merge, and one register stage holds the outcome.

Top module: `sli_unit`

## Requirements
- R1: In each active element of width W and shift s, result bits [s-1:0] equal the destination's old bits and result bits [W-1:s] equal source bits [W-1-s:0].
- R2: Source bits shifted past the top of an element are discarded and never appear in a neighbouring element.
- R3: In the vector form the element width is 8, 16, 32 or 64 bits when the highest set bit of `immh` (bits [22:19]) is bit 0, 1, 2 or 3 respectively.
- R4: The shift amount is the unsigned 7-bit value `{immh, immb}` (bits [22:16]) minus the element width.
- R5: In the vector form, bit 30 (Q) selects a 128-bit active width when 1 and a 64-bit active width when 0; when the active width is 64 bits, result bits [127:64] are zero.
- R6: A vector-form word with `immh[3]`=1 (bit 22) and Q=0 raises `undef_o`.
- R7: A scalar-form word with bit 22 clear raises `undef_o`; otherwise it uses one 64-bit element, a shift of `{immh, immb}` minus 64, and zero upper result bits.
- R8: `rd_o` carries bits [4:0] and `rn_o` carries bits [9:5] of the instruction word.
- R9: A word is recognised only when bits [15:10] are 010101 and bits [31:23] are 011111110 (scalar) or bit 31 is 0, bit 29 is 1 and bits [28:23] are 011110 (vector) with `immh` non-zero; any other word raises `nomatch_o`, and `nomatch_o` and `undef_o` are never high together.
- R10: Outputs are registered: a change on the inputs appears on the outputs after exactly one rising clock edge, and while reset is low every output is zero.
- R11: A shift of zero copies the source unchanged into the active width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_i | input | 32 | Instruction word |
| src_i | input | 128 | Source register value |
| dst_i | input | 128 | Old destination register value |
| result_o | output | 128 | Merged result (registered) |
| undef_o | output | 1 | Recognised but reserved or illegal encoding |
| nomatch_o | output | 1 | Word is not this operation |
| rd_o | output | 5 | Destination register index |
| rn_o | output | 5 | Source register index |

## Verification
On every cycle the assertions check that the two flags never rise together and that the upper half stays zero for 64-bit work. They also check that the register indices follow the word one cycle later, that a zero shift passes the source through, and that bit 0 keeps the destination's value under a non-zero shift. The reserved vector and scalar encodings must also raise the undefined flag. Only the bench's scenarios can show the full per-lane merge for each of the four element widths, the boundary shifts, and the absence of carry between lanes. They are compared against a bit-level reference loop over random data, together with the rejection of malformed words.

// File: rtl/sli_pkg.sv
package sli_pkg;

    localparam int DATA_W = 128;
    localparam int HALF_W = DATA_W / 2;
    localparam int IMM_W  = 7;
    localparam int SH_W   = 6;
    localparam int REG_W  = 5;
    localparam int ESZ_N  = 4;

    // Element width code: width = 8 << code
    typedef enum logic [1:0] {
        ESZ_B = 2'd0,
        ESZ_H = 2'd1,
        ESZ_S = 2'd2,
        ESZ_D = 2'd3
    } esz_e;

    typedef struct packed {
        logic             nomatch;
        logic             undef;
        logic             wide;
        esz_e             esz;
        logic [SH_W-1:0]  shamt;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rn;
    } dec_t;

    localparam logic [5:0] OPC_SLI   = 6'b010101;
    localparam logic [8:0] FIX_SCAL  = 9'b011111110;
    localparam logic [5:0] FIX_VEC_L = 6'b011110;

endpackage

// File: rtl/sli_decode.sv
module sli_decode
    import sli_pkg::*;
(
    input  logic [31:0] insn_i,
    output dec_t        dec_o
);

    logic [3:0]       immh;
    logic [2:0]       immb;
    logic [IMM_W-1:0] imm7;
    logic             opc_ok;
    logic             is_scal;
    logic             is_vec;
    logic             q_bit;
    esz_e             vec_esz;
    logic [IMM_W-1:0] esize_val;

    always_comb begin
        immh    = insn_i[22:19];
        immb    = insn_i[18:16];
        imm7    = {immh, immb};
        q_bit   = insn_i[30];
        opc_ok  = (insn_i[15:10] == OPC_SLI);
        is_scal = opc_ok && (insn_i[31:23] == FIX_SCAL);
        is_vec  = opc_ok && !insn_i[31] && insn_i[29] &&
                  (insn_i[28:23] == FIX_VEC_L) && (immh != 4'b0000);
    end

    // Leading one of immh selects lane width
    always_comb begin
        if (immh[3])      vec_esz = ESZ_D;
        else if (immh[2]) vec_esz = ESZ_S;
        else if (immh[1]) vec_esz = ESZ_H;
        else              vec_esz = ESZ_B;
    end

    always_comb begin
        dec_o.rd      = insn_i[4:0];
        dec_o.rn      = insn_i[9:5];
        dec_o.nomatch = 1'b0;
        dec_o.undef   = 1'b0;
        dec_o.wide    = 1'b0;
        dec_o.esz     = ESZ_D;
        if (is_scal) begin
            dec_o.esz   = ESZ_D;
            dec_o.undef = !immh[3];
        end else if (is_vec) begin
            dec_o.esz   = vec_esz;
            dec_o.wide  = q_bit;
            dec_o.undef = immh[3] && !q_bit;
        end else begin
            dec_o.nomatch = 1'b1;
        end
        esize_val   = 7'd8 << dec_o.esz;
        dec_o.shamt = SH_W'(imm7 - esize_val);
    end

endmodule

// File: rtl/sli_lane_array.sv
module sli_lane_array
    import sli_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int LANE_W = 8
) (
    input  logic [DW-1:0]   src_i,
    input  logic [DW-1:0]   dst_i,
    input  logic [SH_W-1:0] sh_i,
    output logic [DW-1:0]   res_o
);

    localparam int NLANE = DW / LANE_W;

    logic [LANE_W-1:0] keep_mask;

    always_comb keep_mask = {LANE_W{1'b1}} << sh_i;

    for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
        logic [LANE_W-1:0] moved;
        // Shift stays inside the lane slice; overflow bits fall off
        always_comb begin
            moved = src_i[ln*LANE_W +: LANE_W] << sh_i;
            res_o[ln*LANE_W +: LANE_W] =
                (dst_i[ln*LANE_W +: LANE_W] & ~keep_mask) | moved;
        end
    end

endmodule

// File: rtl/sli_unit.sv
module sli_unit
    import sli_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       insn_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    output logic [DATA_W-1:0] result_o,
    output logic              undef_o,
    output logic              nomatch_o,
    output logic [REG_W-1:0]  rd_o,
    output logic [REG_W-1:0]  rn_o
);

    dec_t              dec;
    logic [DATA_W-1:0] lane_res [ESZ_N];
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] res_next;
    logic              wide_q;

    sli_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    for (genvar k = 0; k < ESZ_N; k++) begin : g_size
        sli_lane_array #(
            .DW     (DATA_W),
            .LANE_W (8 << k)
        ) u_lanes (
            .src_i (src_i),
            .dst_i (dst_i),
            .sh_i  (dec.shamt),
            .res_o (lane_res[k])
        );
    end

    always_comb begin
        merged   = lane_res[dec.esz];
        res_next = merged;
        if (!dec.wide) res_next[DATA_W-1:HALF_W] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            undef_o   <= 1'b0;
            nomatch_o <= 1'b0;
            rd_o      <= '0;
            rn_o      <= '0;
            wide_q    <= 1'b0;
        end else begin
            result_o  <= res_next;
            undef_o   <= dec.undef;
            nomatch_o <= dec.nomatch;
            rd_o      <= dec.rd;
            rn_o      <= dec.rn;
            wide_q    <= dec.wide;
        end
    end

    // ---------------- assertions ----------------
    logic chk_vec_form;
    logic chk_scal_form;
    logic chk_ok;

    always_comb begin
        chk_vec_form  = (insn_i[15:10] == 6'b010101) && !insn_i[31] &&
                        insn_i[29] && (insn_i[28:23] == 6'b011110);
        chk_scal_form = (insn_i[15:10] == 6'b010101) &&
                        (insn_i[31:23] == 9'b011111110);
        chk_ok        = !dec.nomatch && !dec.undef;
    end

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(undef_o && nomatch_o));

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |-> (result_o[DATA_W-1:HALF_W] == '0));

    p_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_o == $past(insn_i[4:0]) && rn_o == $past(insn_i[9:5])));

    p_shift_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_ok && dec.shamt == '0) |=> (result_o[HALF_W-1:0] == $past(src_i[HALF_W-1:0])));

    p_keep_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_ok && dec.shamt != '0) |=> (result_o[0] == $past(dst_i[0])));

    p_vec_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vec_form && insn_i[22] && !insn_i[30]) |=> undef_o);

    p_scal_undef_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_scal_form && !insn_i[22]) |=> (undef_o && !nomatch_o));

endmodule

// File: tb/sli_unit_test.sv
module sli_unit_test;

    localparam int CLK_P = 10;
    localparam int NTBL  = 17;

    // Entry: {scalar, q, imm7}
    localparam logic [8:0] TBL [NTBL] = '{
        {1'b0, 1'b0, 7'd8},   {1'b0, 1'b1, 7'd15},  {1'b0, 1'b1, 7'd11},
        {1'b0, 1'b0, 7'd16},  {1'b0, 1'b1, 7'd31},  {1'b0, 1'b1, 7'd25},
        {1'b0, 1'b0, 7'd32},  {1'b0, 1'b1, 7'd63},  {1'b0, 1'b1, 7'd45},
        {1'b0, 1'b1, 7'd64},  {1'b0, 1'b1, 7'd127}, {1'b0, 1'b1, 7'd100},
        {1'b0, 1'b0, 7'd69},  {1'b0, 1'b1, 7'd5},
        {1'b1, 1'b0, 7'd64},  {1'b1, 1'b0, 7'd127}, {1'b1, 1'b0, 7'd40}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  insn_i = '0;
    logic [127:0] src_i = '0;
    logic [127:0] dst_i = '0;
    logic [127:0] result_o;
    logic         undef_o, nomatch_o;
    logic [4:0]   rd_o, rn_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sli_unit uut (
        .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .src_i(src_i), .dst_i(dst_i),
        .result_o(result_o), .undef_o(undef_o), .nomatch_o(nomatch_o),
        .rd_o(rd_o), .rn_o(rn_o)
    );

    function automatic logic [31:0] mk(input logic sc, input logic q,
                                       input logic [6:0] imm, input logic [4:0] rn,
                                       input logic [4:0] rd);
        if (sc) return {9'b011111110, imm, 6'b010101, rn, rd};
        return {1'b0, q, 7'b1011110, imm, 6'b010101, rn, rd};
    endfunction

    // Independent bit-level reference built from the requirements
    task automatic ref_model(input logic [31:0] w, input logic [127:0] s,
                             input logic [127:0] d, output logic [127:0] r,
                             output logic un, output logic nm);
        logic [3:0] immh;
        int es, dw, sh;
        bit opc, scf, vcf;
        immh = w[22:19];
        r = '0; un = 0; nm = 0; es = 64; dw = 64;
        opc = (w[15:10] == 6'b010101);
        scf = opc && (w[31:23] == 9'b011111110);
        vcf = opc && !w[31] && w[29] && (w[28:23] == 6'b011110) && (immh != 0);
        if (!scf && !vcf) begin nm = 1; return; end
        if (scf) begin
            un = !immh[3];
        end else begin
            es = immh[3] ? 64 : immh[2] ? 32 : immh[1] ? 16 : 8;
            dw = w[30] ? 128 : 64;
            un = immh[3] && !w[30];
        end
        if (un) return;
        sh = int'(w[22:16]) - es;
        for (int e = 0; e < dw / es; e++)
            for (int b = 0; b < es; b++) begin
                int idx = e * es + b;
                r[idx] = (b >= sh) ? s[idx - sh] : d[idx];
            end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] w, input logic [127:0] s,
                       input logic [127:0] d, input string req);
        logic [127:0] er;
        logic eu, en;
        ref_model(w, s, d, er, eu, en);
        @(negedge clk);
        insn_i = w; src_i = s; dst_i = d;
        @(posedge clk);
        #1;
        check(undef_o == eu, req, "undef", 128'(undef_o), 128'(eu));
        check(nomatch_o == en, {req, "/R9"}, "nomatch", 128'(nomatch_o), 128'(en));
        check(rd_o == w[4:0] && rn_o == w[9:5], "R8", "rd/rn",
              128'({rd_o, rn_o}), 128'({w[4:0], w[9:5]}));
        if (!eu && !en)
            check(result_o == er, req, "result", result_o, er);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] s, d;
        // R10: reset state
        insn_i = mk(0, 1, 7'd9, 5'd3, 5'd4);
        src_i = {4{32'hDEADBEEF}}; dst_i = {4{32'h12345678}};
        repeat (3) @(posedge clk);
        #1;
        check(result_o == '0 && !undef_o && !nomatch_o && rd_o == 0 && rn_o == 0,
              "R10", "reset outputs", result_o, '0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R11
        for (int i = 0; i < NTBL; i++)
            for (int p = 0; p < 3; p++) begin
                s = {$urandom, $urandom, $urandom, $urandom};
                d = {$urandom, $urandom, $urandom, $urandom};
                if (p == 0) begin s = '1; d = '0; end // R2: all-ones source shows no carry
                run(mk(TBL[i][8], TBL[i][7], TBL[i][6:0], 5'(i), 5'(31 - i)),
                    s, d, "R1/R2/R3/R4/R5/R6/R7/R11");
            end

        // R11: zero shift in 16-bit lanes, source copied
        s = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        run(mk(0, 1, 7'd16, 5'd1, 5'd2), s, '1, "R11");
        check(result_o == s, "R11", "zero shift copy", result_o, s);

        // R1: max shift 8-bit, only lane LSB inserted at top bit
        run(mk(0, 1, 7'd15, 5'd1, 5'd2), {16{8'h01}}, '0, "R1");
        check(result_o == {16{8'h80}}, "R1", "max shift top bit", result_o, {16{8'h80}});

        // R2: 8-bit lanes shift 1 of 0xFF, no carry into next lane
        run(mk(0, 1, 7'd9, 5'd0, 5'd0), '1, '0, "R2");
        check(result_o == {16{8'hFE}}, "R2", "no lane carry", result_o, {16{8'hFE}});

        // R5: Q=0 upper zero
        run(mk(0, 0, 7'd33, 5'd5, 5'd6), '1, '1, "R5");
        check(result_o[127:64] == '0, "R5", "upper zero", result_o, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});

        // R7: scalar shift 4
        run(mk(1, 0, 7'd68, 5'd7, 5'd8), {64'hFFFF, 64'h1}, {64'hAAAA, 64'hF}, "R7");
        check(result_o == 128'h1F, "R7", "scalar merge", result_o, 128'h1F);

        // R9: bad opcode and bad fixed bits
        run(mk(0, 1, 7'd9, 5'd1, 5'd1) ^ 32'h0000_0400, '1, '0, "R9");
        check(nomatch_o && !undef_o, "R9", "bad opcode", 128'(nomatch_o), 128'(1));
        run(mk(0, 1, 7'd9, 5'd1, 5'd1) ^ 32'h2000_0000, '1, '0, "R9");
        check(nomatch_o, "R9", "bad fixed bits", 128'(nomatch_o), 128'(1));

        // R10: one-cycle latency, output holds until the edge
        @(negedge clk);
        insn_i = mk(0, 1, 7'd8, 5'd9, 5'd10); src_i = 128'h55; dst_i = '0;
        #1;
        check(rd_o != 5'd10 || rn_o != 5'd9, "R10", "before edge",
              128'({rd_o, rn_o}), 128'({5'd0, 5'd1}));
        @(posedge clk); #1;
        check(rd_o == 5'd10 && result_o == 128'h55, "R10", "after edge", result_o, 128'h55);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule